// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port synchronous SRAM with a built-in four-beat burst sequencer. Every control is sampled on the rising clock edge. A cycle either loads a fresh external address or continues the current burst. A fresh address can come from a processor-side strobe, which always reads, or from a controller-side strobe, which reads or writes depending on the write controls. Between loads, an advance input steps the two low address bits through a linear or an interleaved order, and the upper address bits stay fixed.

Writes are controlled per byte through a byte-write enable and one strobe per byte, or for the whole word through a global write. Read data reaches the output in one of two ways, chosen by a mode input: straight from the array in the cycle after capture (flow-through), or one cycle later through an output register (pipelined). A deselect turns the outputs off in the cycle right after it is captured. An output enable and a sleep input gate the outputs without waiting for a clock, and sleep also freezes the block while the array keeps its contents.

Top module: `sbs_core`

## Requirements
- R1: After reset, and until a read is captured, `rd_drive` is 0.
- R2: With both chip enables low, `ads_proc_n` low loads `addr` and reads it. With either chip enable high, `ads_proc_n` is ignored, and the cycle behaves as if `ads_proc_n` were high.
- R3: With the chip selected and `ads_proc_n` high, `ads_ctrl_n` low loads `addr`. The cycle writes if a write is requested and reads otherwise. `ads_ctrl_n` low with the chip deselected is a deselect, which ends the burst.
- R4: In a continuing burst, the low two address bits are (start + beat) mod 4 when `lin_order`=1 and start XOR beat when `lin_order`=0. The beat count resets to 0 on every load and steps by one only in cycles with `adv_n` low. Cycles without `adv_n` low repeat the same address.
- R5: `gwe_n` low writes all NB bytes, whatever `bwe_n` and `bstb_n` are.
- R6: With `gwe_n` high and `bwe_n` low, only the bytes whose `bstb_n[i]` is low are written (byte i is `wdata[i*BYTE_W +: BYTE_W]`). If `bwe_n` is high, or all strobes are high, the cycle is a read.
- R7: With `pipe_mode`=0, the data of a read captured at edge N is on `rd_data` after edge N.
- R8: With `pipe_mode`=1, the data of a read captured at edge N is on `rd_data` after edge N+1. It is taken from the array contents before any write at edge N+1.
- R9: A deselect captured at edge N clears `rd_drive` after edge N, in both read modes.
- R10: `oe_n` high forces `rd_drive` to 0 within the same cycle and changes no state. Whenever `rd_drive` is 0, `rd_data` reads all zeros.
- R11: While `sleep` is high, `rd_drive` is 0, all synchronous inputs are ignored, no write happens, and stored data is kept.
- R12: A cycle started by `ads_proc_n` never writes, even with `gwe_n` or `bwe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b_n | input | 1 | Chip enable B, active low |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bstb_n | input | NB | Per-byte write strobes, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous gate |
| addr | input | AW | Word address |
| wdata | input | NB*BYTE_W | Write data |
| rd_data | output | NB*BYTE_W | Read data, zero when not driven |
| rd_drive | output | 1 | Data outputs actively driven |

## Verification
The bench builds the core with AW=6, NB=4 and BYTE_W=9, so 64 words of four 9-bit bytes. That array is small enough to fill completely before any read, so every compare is against a known value. It still has many four-word groups, so bursts wrap at every start offset in both orders. A behavioural model runs next to the design and is compared on every cycle. Directed phases cover the strobes, byte masks, deselect in both read modes, output enable and sleep. A long random phase then mixes every control, including mode changes in the middle of a burst.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // low address bits of a burst beat
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction

  // write requested by the write controls alone
  function automatic logic write_req(input logic gw_n, input logic bw_n,
                                     input logic any_strobe);
    return !gw_n || (!bw_n && any_strobe);
  endfunction
endpackage

// File: rtl/sbs_ctl_decode.sv
module sbs_ctl_decode #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_a_n,
  input  logic          ce_b_n,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          adv_n,
  input  logic          gwe_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bstb_n,
  input  logic          sleep,
  input  logic          active,
  output logic          load,
  output logic          desel,
  output logic          step,
  output logic          rd_en,
  output logic          wr_en,
  output logic [NB-1:0] byte_en
);
  import sbs_pkg::*;

  logic awake, sel, start_p, start_c, cont, wreq;

  assign awake   = !sleep;
  assign sel     = !ce_a_n && !ce_b_n;
  assign start_p = awake && sel && !ads_proc_n;
  assign start_c = awake && sel && ads_proc_n && !ads_ctrl_n;
  assign desel   = awake && !sel && !ads_ctrl_n;
  assign load    = start_p || start_c;
  assign cont    = awake && active && !load && !desel;
  assign step    = cont && !adv_n;
  assign wreq    = write_req(gwe_n, bwe_n, !(&bstb_n));
  assign wr_en   = (start_c || cont) && wreq;
  assign rd_en   = start_p || ((start_c || cont) && !wreq);

  for (genvar b = 0; b < NB; b++) begin : g_ben
    assign byte_en[b] = !gwe_n || (!bwe_n && !bstb_n[b]);
  end

  // R11: asleep means no write
  p_no_write_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !wr_en);
  // R12: processor strobe never writes
  p_proc_reads_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && !ce_a_n && !ce_b_n && !sleep) |-> (rd_en && !wr_en));
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          desel,
  input  logic          step,
  input  logic          lin_order,
  input  logic [AW-1:0] addr,
  output logic          active,
  output logic [AW-1:0] cyc_addr
);
  import sbs_pkg::*;

  logic [AW-3:0] hi_q;
  logic [1:0]    start_q, beat_q, beat_n;
  logic          active_q;

  assign beat_n   = load ? 2'd0 : beat_q + {1'b0, step};
  assign cyc_addr = load ? addr : {hi_q, beat_lo(start_q, beat_n, lin_order)};
  assign active   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      start_q  <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      beat_q <= beat_n;
      if (load) begin
        hi_q     <= addr[AW-1:2];
        start_q  <= addr[1:0];
        active_q <= 1'b1;
      end else if (desel) begin
        active_q <= 1'b0;
      end
    end
  end

  // R4: a load restarts the beat count
  p_load_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_q == 2'd0));
  // R4: the count holds without advance
  p_hold_no_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat_q));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW     = 10,
  parameter int NB     = 4,
  parameter int BYTE_W = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [NB-1:0]    byte_en,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*BYTE_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NB*BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_en[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbs_rd_path.sv
module sbs_rd_path #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          desel,
  input  logic          sleep,
  input  logic          pipe_mode,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_raddr,
  output logic [DW-1:0] q_data,
  output logic          q_live
);
  logic          rd_q, drv_q;
  logic [AW-1:0] cur_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      drv_q <= 1'b0;
      cur_q <= '0;
      out_q <= '0;
    end else begin
      rd_q  <= rd_en;
      drv_q <= rd_q && !desel && !sleep;
      if (rd_en) cur_q <= cyc_addr;
      if (rd_q)  out_q <= arr_rdata;
    end
  end

  assign arr_raddr = cur_q;
  assign q_data    = pipe_mode ? out_q : arr_rdata;
  assign q_live    = pipe_mode ? drv_q : rd_q;
endmodule

// File: rtl/sbs_core.sv
module sbs_core #(
  parameter int AW     = 10,
  parameter int NB     = 4,
  parameter int BYTE_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_a_n,
  input  logic                 ce_b_n,
  input  logic                 ads_proc_n,
  input  logic                 ads_ctrl_n,
  input  logic                 adv_n,
  input  logic                 gwe_n,
  input  logic                 bwe_n,
  input  logic [NB-1:0]        bstb_n,
  input  logic                 lin_order,
  input  logic                 pipe_mode,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic [AW-1:0]        addr,
  input  logic [NB*BYTE_W-1:0] wdata,
  output logic [NB*BYTE_W-1:0] rd_data,
  output logic                 rd_drive
);
  localparam int DW = NB * BYTE_W;

  logic          load, desel, step, rd_en, wr_en, active, q_live;
  logic [NB-1:0] byte_en;
  logic [AW-1:0] cyc_addr, arr_raddr;
  logic [DW-1:0] arr_rdata, q_data;

  sbs_ctl_decode #(.NB(NB)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
    .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .bstb_n(bstb_n), .sleep(sleep),
    .active(active), .load(load), .desel(desel), .step(step),
    .rd_en(rd_en), .wr_en(wr_en), .byte_en(byte_en));

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .desel(desel), .step(step),
    .lin_order(lin_order), .addr(addr), .active(active), .cyc_addr(cyc_addr));

  sbs_array #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .byte_en(byte_en), .waddr(cyc_addr),
    .wdata(wdata), .raddr(arr_raddr), .rdata(arr_rdata));

  sbs_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .desel(desel), .sleep(sleep),
    .pipe_mode(pipe_mode), .cyc_addr(cyc_addr), .arr_rdata(arr_rdata),
    .arr_raddr(arr_raddr), .q_data(q_data), .q_live(q_live));

  assign rd_drive = q_live && !oe_n && !sleep;
  assign rd_data  = rd_drive ? q_data : '0;

  // R9: deselect turns the outputs off at once
  p_desel_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !rd_drive);
  // R10: output enable high means no drive
  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_drive && rd_data == '0));
  // R11: sleep means no drive
  p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_drive);
endmodule

// File: tb/test_sbs_core.sv
module test_sbs_core;
  localparam int AW = 6, NB = 4, BYTE_W = 9, DW = NB * BYTE_W, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_a_n = 1'b1, ce_b_n = 1'b1, ads_proc_n = 1'b1, ads_ctrl_n = 1'b1;
  logic adv_n = 1'b1, gwe_n = 1'b1, bwe_n = 1'b1, lin_order = 1'b1;
  logic pipe_mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [NB-1:0] bstb_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive;

  sbs_core #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) i_sbs_core (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
    .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .bstb_n(bstb_n), .lin_order(lin_order),
    .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_drive(rd_drive));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  logic [DW-1:0] m_mem [DEPTH];
  bit m_active = 0, m_rd = 0, m_pdrv = 0;
  int m_hi = 0, m_start = 0, m_beat = 0, m_cur = 0;
  logic [DW-1:0] m_pdat = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_rd = 0; m_pdrv = 0; m_hi = 0; m_start = 0;
      m_beat = 0; m_cur = 0; m_pdat = '0;
    end else begin
      bit awake, sel, sp, sc, ds, ct, wreq, rd_new;
      int a, lo, nb;
      awake = !sleep;
      sel   = !ce_a_n && !ce_b_n;
      sp    = awake && sel && !ads_proc_n;
      sc    = awake && sel && ads_proc_n && !ads_ctrl_n;
      ds    = awake && !sel && !ads_ctrl_n;
      ct    = awake && m_active && !sp && !sc && !ds;
      wreq  = !gwe_n || (!bwe_n && bstb_n != '1);
      if (sp || sc) begin
        a = int'(addr); nb = 0;
      end else begin
        nb = (ct && !adv_n) ? (m_beat + 1) % 4 : m_beat;
        if (lin_order) lo = (m_start + nb) % 4;
        else           lo = m_start ^ nb;
        a = m_hi * 4 + lo;
      end
      // pipelined output stage sees array before this edge's write
      m_pdrv = m_rd && !ds && awake;
      if (m_rd) m_pdat = m_mem[m_cur];
      if ((sc || ct) && wreq)
        for (int b = 0; b < NB; b++)
          if (!gwe_n || (!bwe_n && !bstb_n[b]))
            m_mem[a][b*BYTE_W +: BYTE_W] = wdata[b*BYTE_W +: BYTE_W];
      rd_new = sp || ((sc || ct) && !wreq);
      if (rd_new) m_cur = a;
      m_rd = rd_new;
      m_beat = nb;
      if (sp || sc) begin
        m_hi = int'(addr) / 4; m_start = int'(addr) % 4; m_active = 1;
      end else if (ds) m_active = 0;
    end
  end

  task automatic check_now();
    bit live, exp_drv;
    logic [DW-1:0] exp_dat;
    live    = pipe_mode ? m_pdrv : m_rd;
    exp_drv = live && !oe_n && !sleep;
    exp_dat = !exp_drv ? '0 : (pipe_mode ? m_pdat : m_mem[m_cur]);
    n_chk++;
    if (rd_drive !== exp_drv) begin
      n_bad++;
      $display("FAIL %s rd_drive actual=%0b expected=%0b t=%0t", cur_req, rd_drive, exp_drv, $time);
    end
    n_chk++;
    if (rd_data !== exp_dat) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, exp_dat, $time);
    end
  endtask

  always @(negedge clk) if (!finished) check_now();

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; bstb_n = '1;
  endtask

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 32'h9E3779B1) ^ (salt * 32'h01000193)) ^ (DW'(a) << 28);
  endfunction

  task automatic proc_burst(int a, bit lin, int beats);
    idle(); ce_a_n = 0; ce_b_n = 0; lin_order = lin;
    ads_proc_n = 0; addr = AW'(a); tick();
    ads_proc_n = 1;
    for (int i = 1; i < beats; i++) begin adv_n = 0; tick(); end
    adv_n = 1;
  endtask

  task automatic deselect();
    idle(); ce_a_n = 1; ads_ctrl_n = 0; tick(); idle(); ce_a_n = 0;
  endtask

  initial begin
    repeat (3) tick();
    cur_req = "R1";
    rst_n = 1; tick(); tick();

    // fill whole array with global write via controller strobe
    cur_req = "R5";
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ce_a_n = 0; ce_b_n = 0; ads_ctrl_n = 0; gwe_n = 0;
      bwe_n = 0; bstb_n = 4'b0101;  // ignored under global write
      addr = AW'(a); wdata = pat(a, 1); tick();
    end
    deselect();

    // burst reads, both orders and both read modes
    for (int pm = 0; pm < 2; pm++) begin
      pipe_mode = pm[0];
      cur_req = pm ? "R8" : "R7";
      for (int s = 0; s < 4; s++) begin
        cur_req = "R4"; proc_burst(20 + s, 1, 4); idle(); tick();
        proc_burst(40 + s, 0, 5); idle(); tick();
      end
      deselect(); tick();
    end

    // processor strobe with write controls: still a read
    cur_req = "R12"; pipe_mode = 0;
    idle(); ads_proc_n = 0; gwe_n = 0; bwe_n = 0; bstb_n = '0;
    addr = 6'd9; wdata = '1; tick(); idle(); tick();
    cur_req = "R2"; proc_burst(9, 1, 1); idle(); tick();

    // byte writes, then reads back
    cur_req = "R6";
    idle(); ads_ctrl_n = 0; bwe_n = 0; bstb_n = 4'b1010; addr = 6'd12;
    wdata = pat(12, 7); tick();
    idle(); ads_ctrl_n = 0; bwe_n = 1; bstb_n = 4'b0000; addr = 6'd13;
    wdata = pat(13, 7); tick();
    idle(); ads_ctrl_n = 0; bwe_n = 0; bstb_n = 4'b1111; addr = 6'd14; tick();
    idle(); proc_burst(12, 1, 4); idle(); tick();

    // controller-strobe write burst with advance and suspend
    cur_req = "R3";
    idle(); ads_ctrl_n = 0; gwe_n = 0; addr = 6'd30; lin_order = 0;
    wdata = pat(30, 3); tick();
    ads_ctrl_n = 1; adv_n = 0; wdata = pat(31, 3); tick();
    cur_req = "R4";
    adv_n = 1; wdata = pat(32, 3); tick();  // same address again
    adv_n = 0; wdata = pat(33, 3); tick();
    idle(); proc_burst(28, 0, 4); idle(); adv_n = 1; tick(); tick();

    // processor strobe while deselected is ignored
    cur_req = "R2";
    proc_burst(5, 1, 2);
    idle(); ce_b_n = 1; ads_proc_n = 0; addr = 6'd50; adv_n = 0; tick();
    idle(); ce_b_n = 0; tick();

    // deselect right after a read, both modes
    for (int pm = 0; pm < 2; pm++) begin
      cur_req = "R9"; pipe_mode = pm[0];
      proc_burst(7, 1, 1);
      idle(); ce_a_n = 1; ads_ctrl_n = 0; tick();
      idle(); ce_a_n = 0; tick(); tick();
    end

    // output enable toggled mid-cycle
    cur_req = "R10"; pipe_mode = 0;
    proc_burst(16, 1, 2);
    oe_n = 1; #1 check_now(); oe_n = 0; #1 check_now();
    oe_n = 1; adv_n = 0; tick(); oe_n = 0; tick(); adv_n = 1;
    deselect();

    // sleep: outputs off, write ignored, data kept
    cur_req = "R11";
    proc_burst(17, 1, 1);
    sleep = 1; #1 check_now();
    idle(); ads_ctrl_n = 0; gwe_n = 0; addr = 6'd17; wdata = '0; tick(); tick();
    sleep = 0; idle(); tick();
    proc_burst(17, 1, 1); idle(); tick();

    // random mix of every control
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      ce_a_n = ($urandom % 8) == 0; ce_b_n = ($urandom % 8) == 0;
      ads_proc_n = ($urandom % 4) != 0; ads_ctrl_n = ($urandom % 4) != 0;
      adv_n = ($urandom % 2) != 0; gwe_n = ($urandom % 6) != 0;
      bwe_n = ($urandom % 2) != 0; bstb_n = NB'($urandom);
      lin_order = ($urandom % 16) != 0 ? lin_order : ~lin_order;
      pipe_mode = ($urandom % 16) != 0 ? pipe_mode : ~pipe_mode;
      oe_n = ($urandom % 10) == 0; sleep = ($urandom % 25) == 0;
      addr = AW'($urandom); wdata = {DW'($urandom), 4'($urandom)};
      tick();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule